// File: doc/BRIEF.md
# Whole-Pulse Gate for Pulse Trains

This block lets a fast pulse train through only while a slower gate signal is active, and it never truncates a pulse. Every pulse that leaves the block is a complete copy of one high phase of the input train. Both inputs are asynchronous. One system clock oversamples them, a synchronizer chain brings each into the clock domain, and edge detectors find their transitions. An internal enable flag changes state only on chosen edges of the pulse train. It never changes directly on a gate transition. The output is the synchronized pulse train ANDed with the flag's next value, and then registered.

A mode input chooses how the gate opens. In drop-first mode, the flag takes the gate level at each falling edge of the pulse train. A pulse that is already running when the gate rises is therefore skipped. In include-first mode, a closed flag opens on the first rising edge of the pulse train seen while the gate is high, so that pulse goes through whole. In both modes the flag closes at the first falling edge of the pulse train that finds the gate low, so a pulse that straddles the gate's fall still finishes.

Typical input pulse rates of 8 kHz to 20 kHz give thousands of system clocks per pulse. The logic does not depend on the rate, so the bench uses pulses only a few clocks long.

Top module: `whole_pulse_gate`

## Requirements
- R1: Every output pulse has the same width, in clock cycles, as the input pulse it copies. No output pulse is ever partial.
- R2: Drop-first mode (`includeFirst` = 0). The gate opens at the first falling edge of the pulse train that samples the gate high. A pulse that is high when the gate rises is not passed.
- R3: In both modes the gate closes at the first falling edge of the pulse train that samples the gate low. A pulse that is high when the gate falls is passed in full. After the gate closes, `gateOpen` reads 0.
- R4: Include-first mode (`includeFirst` = 1). When the flag is clear, it sets on the first rising edge of the pulse train that samples the gate high, and that same pulse is passed in full.
- R5: `pulseOut` follows `pulseIn` by exactly SYNC_STAGES + 1 clock cycles, which is 3 with the default of 2 stages.
- R6: While `rst` is high, `pulseOut` and `gateOpen` are 0 at the next clock edge.
- R7: If the gate rises and falls with no pulse-train edge in between, no output pulse is produced.
- R8: Changing `includeFirst` while the flag is set has no effect on the output.
- R9: `gateOpen` is 1 at some time during a run exactly when at least one pulse was passed.
- R10: For SYNC_STAGES + 1 cycles after reset is released, edges are not detected. A pulse that was already high during reset is therefore never passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both inputs |
| rst | input | 1 | Synchronous reset, active high |
| pulseIn | input | 1 | Asynchronous fast pulse train |
| gateIn | input | 1 | Asynchronous slower gate, active high |
| includeFirst | input | 1 | 1 = include-first mode, 0 = drop-first mode |
| pulseOut | output | 1 | Gated pulse train, whole pulses only |
| gateOpen | output | 1 | Current value of the enable flag |

## Verification
Both inputs pass through synchronizers of the same depth, so the bench describes each scenario on the input timeline. It computes, pulse by pulse, which pulses the rules let through: in drop-first mode from the gate level at each earlier falling edge, in include-first mode from the gate level at each rising and falling edge. It then expects `pulseOut` exactly three cycles after each input sample. Every cycle of a run is compared at the falling clock edge, with input index t − 3. This one comparison checks the latency together with whole-pulse widths. `gateOpen` is judged only where its value is settled: at the end of a run, once the gate has closed and the last falling edge has gone by, and as "was it ever high" against "was any pulse passed".

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  // Edge information handed from the datapath to the control.
  typedef struct packed {
    logic rise;     // rising edge of the synchronized pulse train
    logic fall;     // falling edge of the synchronized pulse train
    logic gateLvl;  // synchronized gate level, aligned with the edges
  } pwg_event_t;

  // Strobes handed from the control to the datapath.
  typedef struct packed {
    logic passNext; // enable value that applies after this edge
    logic setEn;    // flag opens at this edge
    logic clrEn;    // flag closes at this edge
  } pwg_strobe_t;

endpackage

// File: rtl/pwg_sync.sv
module pwg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pwg_datapath.sv
module pwg_datapath
  import pwg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pulseIn,
  input  logic        gateIn,
  input  pwg_strobe_t ctl,
  output pwg_event_t  ev,
  output logic        pulseOut
);

  localparam int WARM_CYCLES = SYNC_STAGES + 1;
  localparam int WARM_W      = $clog2(WARM_CYCLES + 1);

  logic pulseSync;
  logic gateSync;
  logic pulsePrev;
  logic armed;
  logic pulseOutQ;
  logic [WARM_W-1:0] warmCnt;

  pwg_sync #(.STAGES(SYNC_STAGES)) i_pulseSync (
    .clk(clk), .rst(rst), .d(pulseIn), .q(pulseSync)
  );

  pwg_sync #(.STAGES(SYNC_STAGES)) i_gateSync (
    .clk(clk), .rst(rst), .d(gateIn), .q(gateSync)
  );

  // Edge detection stays masked until the synchronizers and the previous-
  // value register hold real samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      warmCnt   <= '0;
      pulsePrev <= 1'b0;
    end else begin
      pulsePrev <= pulseSync;
      if (!armed) warmCnt <= warmCnt + 1'b1;
    end
  end

  assign armed = (warmCnt == WARM_W'(WARM_CYCLES));

  always_comb begin
    ev.rise    = armed & pulseSync & ~pulsePrev;
    ev.fall    = armed & ~pulseSync & pulsePrev;
    ev.gateLvl = gateSync;
  end

  // Output register: synchronized pulse qualified by the next enable value.
  always_ff @(posedge clk) begin
    if (rst) pulseOutQ <= 1'b0;
    else     pulseOutQ <= pulseSync & ctl.passNext;
  end

  assign pulseOut = pulseOutQ;

  // An output pulse may only begin on a detected rising edge.
  assert_whole_start_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOutQ) |-> $past(ev.rise));

  // An output pulse may only end on a detected falling edge (never cut).
  assert_no_cut_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pulseOutQ) |-> $past(ev.fall));

  // Reset drives the output low.
  assert_reset_out_R6: assert property (@(posedge clk)
    rst |=> !pulseOutQ);

endmodule

// File: rtl/pwg_control.sv
module pwg_control
  import pwg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        includeFirst,
  input  pwg_event_t  ev,
  output pwg_strobe_t ctl,
  output logic        enable
);

  logic enQ;

  // The mode only selects the opening edge. While the flag is set, both
  // modes follow the same closing rule.
  always_comb begin
    ctl.setEn    = ~enQ & ev.gateLvl & (includeFirst ? ev.rise : ev.fall);
    ctl.clrEn    = enQ & ev.fall & ~ev.gateLvl;
    ctl.passNext = ctl.setEn | (enQ & ~ctl.clrEn);
  end

  always_ff @(posedge clk) begin
    if (rst) enQ <= 1'b0;
    else     enQ <= ctl.passNext;
  end

  assign enable = enQ;

  assert_open_drop_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(enQ) && !$past(includeFirst)) |-> $past(ev.fall && ev.gateLvl));

  assert_open_incl_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(enQ) && $past(includeFirst)) |-> $past(ev.rise && ev.gateLvl));

  assert_close_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(enQ) |-> $past(ev.fall && !ev.gateLvl));

  assert_reset_flag_R6: assert property (@(posedge clk)
    rst |=> !enQ);

endmodule

// File: rtl/whole_pulse_gate.sv
module whole_pulse_gate
  import pwg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulseIn,
  input  logic gateIn,
  input  logic includeFirst,
  output logic pulseOut,
  output logic gateOpen
);

  pwg_event_t  ev;
  pwg_strobe_t ctl;

  pwg_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rst(rst), .pulseIn(pulseIn), .gateIn(gateIn),
    .ctl(ctl), .ev(ev), .pulseOut(pulseOut)
  );

  pwg_control i_control (
    .clk(clk), .rst(rst), .includeFirst(includeFirst),
    .ev(ev), .ctl(ctl), .enable(gateOpen)
  );

endmodule

// File: tb/test_whole_pulse_gate.sv
module test_whole_pulse_gate;

  localparam int LAT = 3;   // two synchronizer stages + output register
  localparam int P   = 10;  // pulse period in clocks
  localparam int P0  = 6;   // first pulse start after reset release
  localparam int K   = 8;   // pulses per run

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulseIn = 1'b0;
  logic gateIn = 1'b0;
  logic includeFirst = 1'b0;
  logic pulseOut;
  logic gateOpen;

  int total = 0;
  int fails = 0;
  bit passArr [K];

  always #4 clk = ~clk;

  whole_pulse_gate i_whole_pulse_gate (
    .clk(clk), .rst(rst), .pulseIn(pulseIn), .gateIn(gateIn),
    .includeFirst(includeFirst), .pulseOut(pulseOut), .gateOpen(gateOpen)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit gl(input int t, input int gOn, input int gOff);
    return (t >= gOn) && (t < gOff);
  endfunction

  function automatic bit pl(input int u, input int h, input bit preHigh);
    if (u < 0) return 1'b0;
    if (preHigh && u < 5) return 1'b1;
    if (u < P0) return 1'b0;
    if ((u - P0) / P >= K) return 1'b0;
    return ((u - P0) % P) < h;
  endfunction

  function automatic bit expOut(input int u, input int h, input bit preHigh);
    if (u < P0 || !pl(u, h, preHigh)) return 1'b0;
    return passArr[(u - P0) / P];
  endfunction

  task automatic runScenario(input bit mode, input int h, input int gOn,
                             input int gOff, input int switchAt,
                             input bit preHigh, input string req);
    bit en;
    bit anyPass;
    bit sawOpen;
    int mism;
    int firstAct;
    int firstExp;
    int tEnd;
    // Per-pulse pass decision, worked out from the rules on the input timeline.
    en = mode ? 1'b0 : (preHigh && gl(5, gOn, gOff));
    anyPass = 1'b0;
    for (int k = 0; k < K; k++) begin
      int s;
      int e;
      s = P0 + k * P;
      e = s + h;
      if (!mode) begin
        passArr[k] = en;
        en = gl(e, gOn, gOff);
      end else begin
        passArr[k] = en || gl(s, gOn, gOff);
        en = passArr[k] && gl(e, gOn, gOff);
      end
      anyPass |= passArr[k];
    end
    @(negedge clk);
    rst = 1'b1;
    includeFirst = mode;
    pulseIn = preHigh;
    gateIn = gl(0, gOn, gOff);
    repeat (3) @(negedge clk);
    check(pulseOut == 1'b0 && gateOpen == 1'b0, "R6", "outputs in reset",
          {pulseOut, gateOpen}, 0);
    rst = 1'b0;
    mism = 0;
    firstAct = 0;
    firstExp = 0;
    sawOpen = 1'b0;
    tEnd = P0 + K * P + LAT + 3;
    for (int t = 0; t < tEnd; t++) begin
      bit ev;
      ev = (t >= LAT) ? expOut(t - LAT, h, preHigh) : 1'b0;
      if (pulseOut !== ev) begin
        if (mism == 0) begin
          firstAct = pulseOut;
          firstExp = ev;
        end
        mism++;
      end
      if (gateOpen) sawOpen = 1'b1;
      pulseIn = pl(t, h, preHigh);
      gateIn = gl(t, gOn, gOff);
      if (switchAt >= 0 && t == switchAt) includeFirst = ~mode;
      @(negedge clk);
    end
    check(mism == 0, req,
          $sformatf("pulseOut per cycle (mode %0d h %0d on %0d off %0d, %0d bad, first)",
                    mode, h, gOn, gOff, mism), firstAct, firstExp);
    check(gateOpen == 1'b0, "R3", "gateOpen after gate closed", gateOpen, 0);
    check(sawOpen == anyPass, "R9", "gateOpen seen vs pulses passed",
          sawOpen, anyPass);
  endtask

  initial begin
    int hs [3];
    hs[0] = 1;
    hs[1] = 4;
    hs[2] = 9;
    // Main sweep: both modes, three widths, all open/close phases.
    for (int m = 0; m < 2; m++)
      for (int hi = 0; hi < 3; hi++)
        for (int a = 0; a < P; a++)
          for (int b = 0; b < P; b++)
            runScenario(m[0], hs[hi], P0 + 2 * P + a, P0 + 5 * P + b, -1, 1'b0,
                        (m == 0) ? "R2/R1/R5" : "R4/R1/R5");
    // R7: gate pulse inside a low gap, and inside one high phase.
    runScenario(1'b0, 4, P0 + 2 * P + 5, P0 + 2 * P + 8, -1, 1'b0, "R7");
    runScenario(1'b1, 4, P0 + 2 * P + 5, P0 + 2 * P + 8, -1, 1'b0, "R7");
    runScenario(1'b0, 9, P0 + 2 * P + 2, P0 + 2 * P + 6, -1, 1'b0, "R7");
    runScenario(1'b1, 9, P0 + 2 * P + 2, P0 + 2 * P + 6, -1, 1'b0, "R7");
    // R8: mode flipped while the flag is set, expectation stays drop-first.
    for (int a = 0; a < P; a++)
      runScenario(1'b0, 4, P0 + 2 * P + a, P0 + 5 * P + 5, P0 + 4 * P + 1,
                  1'b0, "R8");
    // R10: pulse and gate already high through reset.
    runScenario(1'b1, 4, 0, P0 + 3 * P + 2, -1, 1'b1, "R10");
    runScenario(1'b0, 4, 0, P0 + 3 * P + 2, -1, 1'b1, "R10");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule